// File: doc/BRIEF.md
# Power-Up Configuration Loader over a 2-Wire Serial Memory

When reset is released, this block fetches a stored configuration image from an external 2-wire serial memory. It copies that image into the chip's configuration register file through a simple write port. The block is the bus master. It drives SCL push-pull and pulls SDA low through an output-enable that is meant for an open-drain pad. It never writes the memory and does not arbitrate against other masters.

The first byte of the image is a signature. The block writes the following bytes only when the signature is 0x95. They go to configuration registers 0 up to NREG-1 (110 registers by default), in ascending order. Registers flagged in a status mask are read-only status registers. Their bytes are still read, so the byte stream stays aligned with the register numbers, but they are never written. If no memory answers, or the image is rejected, the register file keeps its default and strap-in contents. Once the load has ended, either way, `done` rises and stays high until the next reset. `error` tells a rejected or broken image apart from an absent memory.

The data flows in one direction only. The register write port is a plain one-cycle strobe with no back-pressure, so the register file must accept a write in every cycle that `cfg_we` is high. Inside the block, the sequencer and the bit engine pass bus operations over a valid/ready pair. A new operation is issued only when the engine is idle.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: The first bus activity after reset release is a START followed by the device byte {DEV_ADDR, 0} (0xA0 for the default device address 0x50).
- R2: After the device acknowledges, the block sends word address 0x00, a repeated START and the device byte {DEV_ADDR, 1} (0xA1), then reads sequentially; exactly two START conditions occur in a full load.
- R3: If the first byte read is not 0x95, cfg_we never pulses, and the block reads one more byte with NACK, issues STOP, and ends with done=1 and error=1.
- R4: With a valid signature, read byte k+1 is written to register k for k = 0..NREG-1, in strictly ascending address order, with cfg_we high for exactly one cycle per write.
- R5: Registers whose bit is set in STATUS_MASK (by default 14, 30, 46, 62 and 78) are never written. Every other register in range is written exactly once.
- R6: The master ACKs every byte it reads except the last one, which gets a NACK, and a STOP follows. A valid load reads NREG+1 bytes.
- R7: If the device byte with write direction is not acknowledged, the block issues STOP and ends with done=1, error=0 and no writes.
- R8: A NACK on the word address or on the device byte with read direction ends the load with STOP, done=1, error=1 and no writes.
- R9: While reset is held, SCL is high, SDA is released, and cfg_we, done and error are 0. Once done is high, it stays high, error keeps its value, and the bus is left idle (SCL high, SDA released) until the next reset.
- R10: done rises no later than 4*QTR_DIV*1200 clock cycles after reset release. With the defaults (QTR_DIV=125, 50 MHz clock, 100 kHz SCL) this is 12 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loading starts when it is released |
| scl_o | output | 1 | Serial clock, driven push-pull |
| sda_oe | output | 1 | When 1, pull SDA low; when 0, release it |
| sda_i | input | 1 | Sensed SDA line level |
| cfg_we | output | 1 | One-cycle write strobe to the register file |
| cfg_addr | output | AW | Register number for the write (AW = clog2(NREG)) |
| cfg_data | output | 8 | Byte to write |
| done | output | 1 | Load finished (sticky until reset) |
| error | output | 1 | Image rejected or device stopped answering mid-setup |

## Verification
The hardest cases to reach from the pins are the failures partway through the setup: a memory that acknowledges its device byte and then refuses the word address, or refuses the read-direction device byte after the repeated START. The bench's behavioural memory model has a separate NACK switch for each phase, so each failure can be forced on its own. A signature mismatch exercises the other awkward path. There the master has already acknowledged the signature and must read one more byte, which it NACKs, before it can legally issue STOP. The model counts the ACKs and NACKs it receives so that this path can be checked.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_STOP  = 2'd1,
    BUS_WR    = 2'd2,
    BUS_RD    = 2'd3
  } bus_op_e;

  // Line levels {scl, pull_low} for quarter q of bit b of an operation.
  function automatic logic [1:0] bus_drive(bus_op_e op, logic [1:0] q, logic [3:0] b,
                                           logic [7:0] wb, logic ak);
    logic       scl;
    logic       oe;
    logic [7:0] t;
    t   = wb << b;
    scl = (q == 2'd1) || (q == 2'd2);
    oe  = 1'b0;
    case (op)
      BUS_START: oe = q[1];
      BUS_STOP: begin
        scl = (q != 2'd0);
        oe  = !q[1];
      end
      BUS_WR:  oe = (b < 4'd8) ? !t[7] : 1'b0;
      default: oe = (b == 4'd8) ? ak : 1'b0;
    endcase
    return {scl, oe};
  endfunction

endpackage

// File: rtl/cfg_ld_bus_engine.sv
module cfg_ld_bus_engine
  import cfg_ld_pkg::*;
#(
  parameter int QTR_DIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_ack,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic       rsp_ack,
  output logic       scl_o,
  output logic       sda_oe,
  input  logic       sda_i
);

  localparam int CW = $clog2(QTR_DIV + 1);

  logic          busy;
  bus_op_e       op;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic [7:0]    wbyte;
  logic          ackq;
  logic [7:0]    shreg;
  logic          gotack;
  logic [3:0]    last_bit;

  assign cmd_ready = !busy;
  assign rsp_byte  = shreg;
  assign rsp_ack   = gotack;
  assign last_bit  = (op == BUS_START || op == BUS_STOP) ? 4'd0 : 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op        <= BUS_STOP;
      q         <= 2'd0;
      bitn      <= 4'd0;
      cnt       <= '0;
      wbyte     <= 8'h00;
      ackq      <= 1'b0;
      shreg     <= 8'h00;
      gotack    <= 1'b0;
      rsp_valid <= 1'b0;
      scl_o     <= 1'b1;
      sda_oe    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy            <= 1'b1;
          op              <= cmd_op;
          q               <= 2'd0;
          bitn            <= 4'd0;
          cnt             <= '0;
          wbyte           <= cmd_byte;
          ackq            <= cmd_ack;
          {scl_o, sda_oe} <= bus_drive(cmd_op, 2'd0, 4'd0, cmd_byte, cmd_ack);
        end
      end else if (cnt == CW'(QTR_DIV - 1)) begin
        cnt <= '0;
        if (q == 2'd1) begin
          if (op == BUS_RD && bitn < 4'd8) shreg <= {shreg[6:0], sda_i};
          if (op == BUS_WR && bitn == 4'd8) gotack <= !sda_i;
        end
        if (q != 2'd3) begin
          q               <= q + 2'd1;
          {scl_o, sda_oe} <= bus_drive(op, q + 2'd1, bitn, wbyte, ackq);
        end else if (bitn == last_bit) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
        end else begin
          q               <= 2'd0;
          bitn            <= bitn + 4'd1;
          {scl_o, sda_oe} <= bus_drive(op, 2'd0, bitn + 4'd1, wbyte, ackq);
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq
  import cfg_ld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] SIGNATURE = 8'h95,
  parameter int         NREG      = 110,
  parameter int         AW        = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output bus_op_e       cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_ack,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_byte,
  input  logic          rsp_ack,
  output logic          byte_valid,
  output logic [AW-1:0] byte_idx,
  output logic [7:0]    byte_data,
  output logic          done,
  output logic          error
);

  typedef enum logic [3:0] {
    SQ_START, SQ_DEVW, SQ_WORD, SQ_RSTART, SQ_DEVR,
    SQ_SIG, SQ_DATA, SQ_FLUSH, SQ_STOP, SQ_DONE
  } seq_e;

  localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

  seq_e          state;
  logic          pend;
  logic [AW-1:0] idx;

  assign cmd_valid = !pend && (state != SQ_DONE);
  assign done      = (state == SQ_DONE);

  always_comb begin
    cmd_op   = BUS_RD;
    cmd_byte = 8'h00;
    cmd_ack  = 1'b0;
    case (state)
      SQ_START, SQ_RSTART: cmd_op = BUS_START;
      SQ_DEVW: begin cmd_op = BUS_WR; cmd_byte = {DEV_ADDR, 1'b0}; end
      SQ_WORD: cmd_op = BUS_WR;
      SQ_DEVR: begin cmd_op = BUS_WR; cmd_byte = {DEV_ADDR, 1'b1}; end
      SQ_SIG:  cmd_ack = 1'b1;
      SQ_DATA: cmd_ack = (idx != LAST_IDX);
      SQ_STOP, SQ_DONE: cmd_op = BUS_STOP;
      default: cmd_ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_START;
      pend       <= 1'b0;
      idx        <= '0;
      error      <= 1'b0;
      byte_valid <= 1'b0;
      byte_idx   <= '0;
      byte_data  <= 8'h00;
    end else begin
      byte_valid <= 1'b0;
      if (cmd_valid && cmd_ready) pend <= 1'b1;
      if (rsp_valid) begin
        pend <= 1'b0;
        case (state)
          SQ_START:  state <= SQ_DEVW;
          SQ_DEVW:   state <= rsp_ack ? SQ_WORD : SQ_STOP;
          SQ_WORD: begin
            state <= rsp_ack ? SQ_RSTART : SQ_STOP;
            if (!rsp_ack) error <= 1'b1;
          end
          SQ_RSTART: state <= SQ_DEVR;
          SQ_DEVR: begin
            state <= rsp_ack ? SQ_SIG : SQ_STOP;
            if (!rsp_ack) error <= 1'b1;
          end
          SQ_SIG: begin
            idx <= '0;
            if (rsp_byte == SIGNATURE) begin
              state <= SQ_DATA;
            end else begin
              state <= SQ_FLUSH;
              error <= 1'b1;
            end
          end
          SQ_DATA: begin
            byte_valid <= 1'b1;
            byte_idx   <= idx;
            byte_data  <= rsp_byte;
            if (idx == LAST_IDX) state <= SQ_STOP;
            else idx <= idx + AW'(1);
          end
          SQ_FLUSH:  state <= SQ_STOP;
          SQ_STOP:   state <= SQ_DONE;
          default:   state <= SQ_DONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_ld_wrport.sv
module cfg_ld_wrport #(
  parameter int           NREG        = 110,
  parameter int           AW          = $clog2(NREG),
  parameter logic [127:0] STATUS_MASK = 128'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [AW-1:0] byte_idx,
  input  logic [7:0]    byte_data,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [7:0]    cfg_data
);

  localparam int NSLOT = 1 << AW;

  logic [NSLOT-1:0] writable;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NREG) begin : g_in
      assign writable[g] = !STATUS_MASK[g];
    end else begin : g_out
      assign writable[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_we   <= 1'b0;
      cfg_addr <= '0;
      cfg_data <= 8'h00;
    end else begin
      cfg_we <= byte_valid && writable[byte_idx];
      if (byte_valid) begin
        cfg_addr <= byte_idx;
        cfg_data <= byte_data;
      end
    end
  end

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_ld_pkg::*;
#(
  parameter int           QTR_DIV     = 125,
  parameter logic [6:0]   DEV_ADDR    = 7'h50,
  parameter logic [7:0]   SIGNATURE   = 8'h95,
  parameter int           NREG        = 110,
  parameter logic [127:0] STATUS_MASK = 128'h0000_0000_0000_4000_4000_4000_4000_4000,
  localparam int          AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          scl_o,
  output logic          sda_oe,
  input  logic          sda_i,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [7:0]    cfg_data,
  output logic          done,
  output logic          error
);

  logic [1:0]    sda_sync;
  logic          cmd_valid, cmd_ready, cmd_ack;
  bus_op_e       cmd_op;
  logic [7:0]    cmd_byte;
  logic          rsp_valid, rsp_ack;
  logic [7:0]    rsp_byte;
  logic          byte_valid;
  logic [AW-1:0] byte_idx;
  logic [7:0]    byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_sync <= 2'b11;
    else        sda_sync <= {sda_sync[0], sda_i};
  end

  cfg_ld_bus_engine #(.QTR_DIV(QTR_DIV)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ack(rsp_ack),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_sync[1])
  );

  cfg_ld_seq #(
    .DEV_ADDR(DEV_ADDR), .SIGNATURE(SIGNATURE), .NREG(NREG), .AW(AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ack(rsp_ack),
    .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
    .done(done), .error(error)
  );

  cfg_ld_wrport #(.NREG(NREG), .AW(AW), .STATUS_MASK(STATUS_MASK)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
  parameter int           QTR_DIV     = 125,
  parameter int           NREG        = 110,
  parameter int           AW          = 7,
  parameter logic [127:0] STATUS_MASK = 128'h0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_o,
  input logic          sda_oe,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic          done,
  input logic          error
);

  localparam int BOUND = 4 * QTR_DIV * 1200;

  logic          seen;
  logic [AW-1:0] last_addr;
  int            elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_addr <= '0;
      elapsed   <= 0;
    end else begin
      if (cfg_we) begin
        seen      <= 1'b1;
        last_addr <= cfg_addr;
      end
      if (!done && elapsed <= BOUND) elapsed <= elapsed + 1;
    end
  end

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (int'(cfg_addr) < NREG));

  a_r4_addr_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && seen) |-> (cfg_addr > last_addr));

  a_r5_status_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !STATUS_MASK[cfg_addr]);

  a_r3_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !cfg_we);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  a_r9_bus_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_o && !sda_oe && !cfg_we));

  a_r10_time_budget: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (elapsed <= BOUND));

endmodule

bind cfg_eeprom_loader cfg_loader_checker #(
  .QTR_DIV(QTR_DIV), .NREG(NREG), .AW(AW), .STATUS_MASK(STATUS_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe(sda_oe),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .done(done), .error(error)
);

// File: tb/tb_cfg_eeprom_loader.sv
module tb_cfg_eeprom_loader;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 2;
  localparam int NREG       = 110;
  localparam int BOUND      = 4 * QTR * 1200;
  // {addr[6:0], expect_written}
  localparam logic [7:0] TBL [10] = '{8'h01, 8'h1B, 8'h1C, 8'h1F, 8'h3C,
                                      8'h5C, 8'h7C, 8'h9B, 8'h9C, 8'hDB};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_o, sda_oe, cfg_we, done, error;
  logic [6:0] cfg_addr;
  logic [7:0] cfg_data;
  logic       drv = 1'b0;
  wire        sda_line = ~(sda_oe | drv);

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_eeprom_loader #(.QTR_DIV(QTR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .done(done), .error(error)
  );

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  bit   m_present, m_nack_dw, m_nack_word, m_nack_dr;
  bit   m_rx, m_tx, m_isaddr, m_rw, m_acked, m_mack;
  bit   ps = 1'b1, pd = 1'b1;
  int   bitn;
  logic [7:0] sh, cur, ptr;
  logic [7:0] rxlog [8];
  int   rxn, starts, stops, txn, acks, nacks;

  always @(negedge clk) begin
    bit cs, cd;
    cs = scl_o;
    cd = sda_line;
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; drv = 0; bitn = 0;
      rxn = 0; starts = 0; stops = 0; txn = 0; acks = 0; nacks = 0;
    end else if (ps && cs && pd && !cd) begin
      starts++; m_rx = 1; m_tx = 0; bitn = 0; m_isaddr = 1; drv = 0;
    end else if (ps && cs && !pd && cd) begin
      stops++; m_rx = 0; m_tx = 0; drv = 0;
    end else if (!ps && cs) begin
      if (m_rx) begin
        if (bitn < 8) sh = {sh[6:0], cd};
        bitn++;
      end else if (m_tx) begin
        bitn++;
        if (bitn == 9) begin
          m_mack = !cd; txn++;
          if (m_mack) acks++; else nacks++;
        end
      end
    end else if (ps && !cs) begin
      if (m_rx && bitn == 8) begin
        if (rxn < 8) rxlog[rxn] = sh;
        rxn++;
        if (m_isaddr) begin
          m_rw = sh[0];
          m_acked = m_present && (sh[7:1] == 7'h50) && !(m_rw ? m_nack_dr : m_nack_dw);
        end else begin
          ptr = sh; m_acked = !m_nack_word;
        end
        drv = m_acked;
      end else if (m_rx && bitn == 9) begin
        drv = 0; bitn = 0;
        if (!m_acked) m_rx = 0;
        else if (m_isaddr && m_rw) begin
          m_rx = 0; m_tx = 1; cur = mem[ptr]; drv = !cur[7];
        end
        m_isaddr = 0;
      end else if (m_tx) begin
        if (bitn >= 1 && bitn <= 7) drv = !cur[7-bitn];
        else if (bitn == 8) drv = 0;
        else if (bitn == 9) begin
          if (m_mack) begin
            ptr++; cur = mem[ptr]; bitn = 0; drv = !cur[7];
          end else begin
            m_tx = 0; drv = 0;
          end
        end
      end
    end
    ps = cs; pd = cd;
  end

  // ---------------- write monitor ----------------
  logic [7:0] got [128];
  bit   wflag [128];
  int   wr_cnt, last_wr;
  bit   order_bad;

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_cnt = 0; last_wr = -1; order_bad = 0;
      for (int i = 0; i < 128; i++) wflag[i] = 0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) <= last_wr || wflag[cfg_addr]) order_bad = 1;
      last_wr = int'(cfg_addr);
      wflag[cfg_addr] = 1;
      got[cfg_addr] = cfg_data;
      wr_cnt++;
    end
  end

  function automatic logic [7:0] img(int k);
    return 8'(k * 37 + 11) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_load(input logic [7:0] sig, input bit pres, input bit ndw,
                          input bit nword, input bit ndr, output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    m_present = pres; m_nack_dw = ndw; m_nack_word = nword; m_nack_dr = ndr;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[0] = sig;
    for (int k = 0; k < NREG; k++) mem[k + 1] = img(k);
    repeat (4) @(negedge clk);
    // R9: quiet outputs during reset
    chk(scl_o && !sda_oe && !cfg_we && !done && !error, "R9 reset state",
        {scl_o, sda_oe, cfg_we, done, error}, 5'b10000);
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int cyc, w0;

    // ---- valid image ----
    run_load(8'h95, 1, 0, 0, 0, cyc);
    chk(done && !error, "R4 done without error", {done, error}, 2'b10);
    chk(cyc <= BOUND, "R10 load time", cyc, BOUND);
    chk(rxn == 3 && rxlog[0] == 8'hA0, "R1 first device byte", rxlog[0], 8'hA0);
    chk(rxlog[1] == 8'h00 && rxlog[2] == 8'hA1, "R2 word addr and read byte",
        {rxlog[1], rxlog[2]}, 16'h00A1);
    chk(starts == 2, "R2 start count", starts, 2);
    chk(txn == NREG + 1 && acks == NREG && nacks == 1, "R6 ack pattern",
        {txn[7:0], nacks[7:0]}, {8'(NREG + 1), 8'd1});
    chk(stops == 1 && !m_tx, "R6 stop after last", stops, 1);
    chk(wr_cnt == NREG - 5, "R5 write count", wr_cnt, NREG - 5);
    chk(!order_bad, "R4 ascending single writes", order_bad, 0);
    for (int t = 0; t < 10; t++) begin
      int a;
      a = int'(TBL[t][7:1]);
      if (TBL[t][0])
        chk(wflag[a] && got[a] == img(a), "R4 register content", got[a], img(a));
      else
        chk(!wflag[a], "R5 status register skipped", wflag[a], 0);
    end
    w0 = wr_cnt;
    repeat (60) @(negedge clk);
    chk(done && !error && scl_o && !sda_oe && wr_cnt == w0, "R9 sticky idle after done",
        {done, error, scl_o, sda_oe}, 4'b1010);

    // ---- bad signature ----
    run_load(8'h94, 1, 0, 0, 0, cyc);
    chk(done && error, "R3 mismatch flags", {done, error}, 2'b11);
    chk(wr_cnt == 0, "R3 no writes", wr_cnt, 0);
    chk(txn == 2 && nacks == 1 && stops == 1, "R3 flush byte then stop",
        {txn[7:0], nacks[7:0]}, 16'h0201);

    // ---- no device ----
    run_load(8'h95, 0, 0, 0, 0, cyc);
    chk(done && !error, "R7 absent device flags", {done, error}, 2'b10);
    chk(wr_cnt == 0 && rxn == 1 && stops == 1, "R7 stop, no writes", wr_cnt, 0);

    // ---- device NACKs write-direction byte though present ----
    run_load(8'h95, 1, 1, 0, 0, cyc);
    chk(done && !error && wr_cnt == 0, "R7 nack on device write byte",
        {done, error}, 2'b10);

    // ---- NACK on word address ----
    run_load(8'h95, 1, 0, 1, 0, cyc);
    chk(done && error && wr_cnt == 0 && rxn == 2, "R8 word address nack",
        {done, error, rxn[3:0]}, 6'b110010);

    // ---- NACK on read-direction device byte ----
    run_load(8'h95, 1, 0, 0, 1, cyc);
    chk(done && error && wr_cnt == 0 && rxn == 3, "R8 read address nack",
        {done, error, rxn[3:0]}, 6'b110011);
    chk(stops == 1 && scl_o && !sda_oe, "R8 stop issued", stops, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule